// File: doc/BRIEF.md
# Task Stall Manager with Dispatch Lock

This block controls a fixed set of hardware task units that all run in parallel. Each unit gets one stall line: the unit halts while its line is high and runs while it is low. For every task the block keeps a status record with four fields: a scheduling state, a current priority, a base priority and a countdown timer. A task that becomes Ready is promoted to Running on the following clock. Only Running tasks are released.

Task units change status by issuing commands on one shared command port. A command is accepted only from the task that currently holds the single service-call lock. A task asks for the lock on its own request line and returns it by issuing an unlock command, so status changes happen one at a time.

The block also has a global dispatch-disable register. It holds an enable flag and the ID of the task that set it. While the flag is set, every other task is forced to stall, which gives that task mutual exclusion. A shared tick input counts down every nonzero task timer. A Blocked task whose timer runs out becomes Ready. A read port returns the status record of any selected task.

Top module: `task_stall_mgr`

## Requirements
- R1: While `rst` is high, every stall line is 1, no lock grant is given, and each task reads back state Ready (code 01) with priority, base priority and timer equal to 0.
- R2: State codes are Running=00, Ready=01, Blocked=10 and Suspended=11. A Ready task becomes Running on the next clock. A task's stall line, registered one clock behind its state, is 0 exactly when the task is Running and dispatch is not disabled by another task.
- R3: A suspend command (op code 1) puts the target into Suspended from any state.
- R4: A resume command (op code 2) moves the target to Ready only if it is Suspended. In any other state the target is left unchanged.
- R5: A delay command (op code 3) puts the target into Blocked and loads its timer with the command data. A loaded value of 0 never expires.
- R6: Each clock with `tick_i` high decrements every nonzero timer by one. A Blocked task whose timer goes from 1 to 0 becomes Ready.
- R7: A wake command (op code 4) moves a Blocked target to Ready and clears its timer. In any other state the target is left unchanged.
- R8: Op code 5 writes the current priority and op code 6 writes the base priority from the low bits of the command data. The read port returns the selected task's record one clock after `rd_id_i` is applied.
- R9: When the lock is free and one or more tasks request it, the lock goes to the lowest-numbered requester. Its one-hot grant then stays unchanged until that holder issues an unlock command (op code 9). At most one grant bit is ever high.
- R10: A command whose source ID is not the current lock holder has no effect.
- R11: A dispatch-off command (op code 7) sets the disable flag and records the issuing task's ID. While the flag is set, every task other than the recorded one is stalled.
- R12: A dispatch-on command (op code 8) clears the flag, and the stall lines return to the values their states give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_req_i | input | NUM_TASKS | Per-task request for the service-call lock |
| lock_grant_o | output | NUM_TASKS | One-hot lock holder, all zero when free |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_src_i | input | ID_W | ID of the issuing task |
| cmd_op_i | input | 4 | Command code |
| cmd_tgt_i | input | ID_W | Target task ID |
| cmd_data_i | input | TIMER_W | Timer load or priority value |
| tick_i | input | 1 | Timer tick pulse |
| stall_o | output | NUM_TASKS | Registered stall line per task |
| rd_id_i | input | ID_W | Task selected for status readback |
| rd_state_o | output | 2 | State of the selected task |
| rd_prio_o | output | PRIO_W | Current priority of the selected task |
| rd_base_o | output | PRIO_W | Base priority of the selected task |
| rd_timer_o | output | TIMER_W | Timer of the selected task |

## Verification
The bench uses the default parameters: four tasks, 3-bit priorities and 8-bit timers. With four tasks, two requesters can contend for the lock while a third task acts as an outside party whose commands must be ignored. Four tasks also give a mask pattern in which only the dispatch owner is left running. With an 8-bit timer, a short delay of five ticks can be followed tick by tick down to its expiry, and the zero load that never expires can be checked on the same task.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  typedef enum logic [1:0] {
    TS_RUN = 2'b00,
    TS_RDY = 2'b01,
    TS_BLK = 2'b10,
    TS_SUS = 2'b11
  } tstate_e;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 4'd0,
    OP_SUSPEND  = 4'd1,
    OP_RESUME   = 4'd2,
    OP_DELAY    = 4'd3,
    OP_WAKE     = 4'd4,
    OP_SETPRIO  = 4'd5,
    OP_SETBASE  = 4'd6,
    OP_DISP_OFF = 4'd7,
    OP_DISP_ON  = 4'd8,
    OP_UNLOCK   = 4'd9
  } op_e;

endpackage

// File: rtl/tsm_lock_arb.sv
module tsm_lock_arb #(
  parameter int N    = 4,
  parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_i,
  input  logic            release_i,
  output logic            busy_o,
  output logic [ID_W-1:0] owner_o,
  output logic [N-1:0]    grant_o
);

  logic            busy_q;
  logic [ID_W-1:0] owner_q;
  logic [ID_W-1:0] first_id;

  // lowest-numbered active requester wins
  always_comb begin
    first_id = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) first_id = ID_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (busy_q) begin
      if (release_i) busy_q <= 1'b0;
    end else if (|req_i) begin
      busy_q  <= 1'b1;
      owner_q <= first_id;
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_grant
      assign grant_o[g] = busy_q && (owner_q == ID_W'(g));
    end
  endgenerate

  assign busy_o  = busy_q;
  assign owner_o = owner_q;

endmodule

// File: rtl/tsm_task_slot.sv
module tsm_task_slot
  import tsm_pkg::*;
#(
  parameter int PRIO_W  = 3,
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [TIMER_W-1:0] data_i,
  input  logic               tick_i,
  output logic [1:0]         state_o,
  output logic [PRIO_W-1:0]  prio_o,
  output logic [PRIO_W-1:0]  base_o,
  output logic [TIMER_W-1:0] timer_o
);

  tstate_e            st_q, st_n;
  logic [PRIO_W-1:0]  prio_q, prio_n;
  logic [PRIO_W-1:0]  base_q, base_n;
  logic [TIMER_W-1:0] tmr_q, tmr_n;

  always_comb begin
    st_n   = (st_q == TS_RDY) ? TS_RUN : st_q;
    prio_n = prio_q;
    base_n = base_q;
    tmr_n  = tmr_q;
    if (tick_i && (tmr_q != '0)) begin
      tmr_n = tmr_q - 1'b1;
      if ((tmr_q == TIMER_W'(1)) && (st_q == TS_BLK)) st_n = TS_RDY;
    end
    if (hit_i) begin
      case (op_e'(op_i))
        OP_SUSPEND: st_n = TS_SUS;
        OP_RESUME:  if (st_q == TS_SUS) st_n = TS_RDY;
        OP_DELAY: begin
          st_n  = TS_BLK;
          tmr_n = data_i;
        end
        OP_WAKE: if (st_q == TS_BLK) begin
          st_n  = TS_RDY;
          tmr_n = '0;
        end
        OP_SETPRIO: prio_n = data_i[PRIO_W-1:0];
        OP_SETBASE: base_n = data_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TS_RDY;
      prio_q <= '0;
      base_q <= '0;
      tmr_q  <= '0;
    end else begin
      st_q   <= st_n;
      prio_q <= prio_n;
      base_q <= base_n;
      tmr_q  <= tmr_n;
    end
  end

  assign state_o = st_q;
  assign prio_o  = prio_q;
  assign base_o  = base_q;
  assign timer_o = tmr_q;

endmodule

// File: rtl/tsm_stall_gen.sv
module tsm_stall_gen #(
  parameter int N    = 4,
  parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    run_i,
  input  logic            dis_flag_i,
  input  logic [ID_W-1:0] dis_owner_i,
  output logic [N-1:0]    stall_o
);

  logic [N-1:0] owner_dec;
  logic [N-1:0] stall_d;
  logic [N-1:0] stall_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_line
      assign owner_dec[g] = (dis_owner_i == ID_W'(g));
      assign stall_d[g]   = (dis_flag_i && !owner_dec[g]) ? 1'b1 : !run_i[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stall_q <= '1;
    else     stall_q <= stall_d;
  end

  assign stall_o = stall_q;

endmodule

// File: rtl/task_stall_mgr.sv
module task_stall_mgr
  import tsm_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int PRIO_W    = 3,
  parameter int TIMER_W   = 8,
  parameter int ID_W      = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TASKS-1:0] lock_req_i,
  output logic [NUM_TASKS-1:0] lock_grant_o,
  input  logic                 cmd_valid_i,
  input  logic [ID_W-1:0]      cmd_src_i,
  input  logic [3:0]           cmd_op_i,
  input  logic [ID_W-1:0]      cmd_tgt_i,
  input  logic [TIMER_W-1:0]   cmd_data_i,
  input  logic                 tick_i,
  output logic [NUM_TASKS-1:0] stall_o,
  input  logic [ID_W-1:0]      rd_id_i,
  output logic [1:0]           rd_state_o,
  output logic [PRIO_W-1:0]    rd_prio_o,
  output logic [PRIO_W-1:0]    rd_base_o,
  output logic [TIMER_W-1:0]   rd_timer_o
);

  logic            lock_busy;
  logic [ID_W-1:0] lock_owner;
  logic            cmd_ok;
  logic            unlock_hit;
  logic            dis_flag_q;
  logic [ID_W-1:0] dis_owner_q;
  logic [NUM_TASKS-1:0] run_vec;

  logic [1:0]         st_arr   [NUM_TASKS];
  logic [PRIO_W-1:0]  prio_arr [NUM_TASKS];
  logic [PRIO_W-1:0]  base_arr [NUM_TASKS];
  logic [TIMER_W-1:0] tmr_arr  [NUM_TASKS];

  assign cmd_ok     = cmd_valid_i && lock_busy && (lock_owner == cmd_src_i);
  assign unlock_hit = cmd_ok && (cmd_op_i == OP_UNLOCK);

  tsm_lock_arb #(.N(NUM_TASKS), .ID_W(ID_W)) lock_i (
    .clk(clk), .rst(rst), .req_i(lock_req_i), .release_i(unlock_hit),
    .busy_o(lock_busy), .owner_o(lock_owner), .grant_o(lock_grant_o)
  );

  generate
    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_slot
      logic hit;
      assign hit = cmd_ok && (cmd_tgt_i == ID_W'(g));
      tsm_task_slot #(.PRIO_W(PRIO_W), .TIMER_W(TIMER_W)) slot_i (
        .clk(clk), .rst(rst), .hit_i(hit), .op_i(cmd_op_i),
        .data_i(cmd_data_i), .tick_i(tick_i),
        .state_o(st_arr[g]), .prio_o(prio_arr[g]),
        .base_o(base_arr[g]), .timer_o(tmr_arr[g])
      );
      assign run_vec[g] = (st_arr[g] == TS_RUN);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_flag_q  <= 1'b0;
      dis_owner_q <= '0;
    end else if (cmd_ok && (cmd_op_i == OP_DISP_OFF)) begin
      dis_flag_q  <= 1'b1;
      dis_owner_q <= cmd_src_i;
    end else if (cmd_ok && (cmd_op_i == OP_DISP_ON)) begin
      dis_flag_q  <= 1'b0;
    end
  end

  tsm_stall_gen #(.N(NUM_TASKS), .ID_W(ID_W)) stall_i (
    .clk(clk), .rst(rst), .run_i(run_vec), .dis_flag_i(dis_flag_q),
    .dis_owner_i(dis_owner_q), .stall_o(stall_o)
  );

  // readback register, not reset
  always_ff @(posedge clk) begin
    rd_state_o <= st_arr[rd_id_i];
    rd_prio_o  <= prio_arr[rd_id_i];
    rd_base_o  <= base_arr[rd_id_i];
    rd_timer_o <= tmr_arr[rd_id_i];
  end

endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
  parameter int N    = 4,
  parameter int ID_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    lock_req_i,
  input logic [N-1:0]    lock_grant_o,
  input logic            cmd_valid_i,
  input logic [ID_W-1:0] cmd_src_i,
  input logic [3:0]      cmd_op_i,
  input logic [N-1:0]    stall_o,
  input logic            dis_flag_q,
  input logic [ID_W-1:0] dis_owner_q,
  input logic [N-1:0]    run_vec
);

  logic unlock_seen;
  assign unlock_seen = cmd_valid_i && (cmd_op_i == 4'd9) && lock_grant_o[cmd_src_i];

  // R1
  reset_stall_chk: assert property (@(posedge clk) rst |=> &stall_o);

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lock_grant_o));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((|lock_grant_o) && !unlock_seen) |=> $stable(lock_grant_o));

  // R9
  lock_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    ((lock_grant_o == '0) && (|lock_req_i)) |=>
      (lock_grant_o == ($past(lock_req_i) & (~$past(lock_req_i) + 1'b1))));

  // R11
  dispatch_mask_chk: assert property (@(posedge clk) disable iff (rst)
    dis_flag_q |=> &(stall_o | (N'(1) << $past(dis_owner_q))));

  // R2
  run_release_chk: assert property (@(posedge clk) disable iff (rst)
    !dis_flag_q |=> (stall_o == ~$past(run_vec)));

endmodule

bind task_stall_mgr tsm_checker #(.N(NUM_TASKS), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst(rst), .lock_req_i(lock_req_i), .lock_grant_o(lock_grant_o),
  .cmd_valid_i(cmd_valid_i), .cmd_src_i(cmd_src_i), .cmd_op_i(cmd_op_i),
  .stall_o(stall_o), .dis_flag_q(dis_flag_q), .dis_owner_q(dis_owner_q),
  .run_vec(run_vec)
);

// File: tb/task_stall_mgr_tb.sv
module task_stall_mgr_tb_top;

  localparam int N = 4;
  localparam int IW = 2;
  localparam int PW = 3;
  localparam int TW = 8;

  localparam logic [3:0] C_SUSP = 4'd1, C_RES = 4'd2, C_DLY = 4'd3, C_WAKE = 4'd4,
                         C_PRIO = 4'd5, C_BASE = 4'd6, C_DOFF = 4'd7, C_DON = 4'd8,
                         C_UNL = 4'd9;
  localparam logic [1:0] S_RUN = 2'b00, S_RDY = 2'b01, S_BLK = 2'b10, S_SUS = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] lock_req = '0;
  logic [N-1:0] lock_grant;
  logic cmd_valid = 1'b0;
  logic [IW-1:0] cmd_src = '0;
  logic [3:0] cmd_op = '0;
  logic [IW-1:0] cmd_tgt = '0;
  logic [TW-1:0] cmd_data = '0;
  logic tick = 1'b0;
  logic [N-1:0] stall;
  logic [IW-1:0] rd_id = '0;
  logic [1:0] rd_state;
  logic [PW-1:0] rd_prio, rd_base;
  logic [TW-1:0] rd_timer;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  task_stall_mgr #(.NUM_TASKS(N), .PRIO_W(PW), .TIMER_W(TW)) dut_i (
    .clk(clk), .rst(rst), .lock_req_i(lock_req), .lock_grant_o(lock_grant),
    .cmd_valid_i(cmd_valid), .cmd_src_i(cmd_src), .cmd_op_i(cmd_op),
    .cmd_tgt_i(cmd_tgt), .cmd_data_i(cmd_data), .tick_i(tick), .stall_o(stall),
    .rd_id_i(rd_id), .rd_state_o(rd_state), .rd_prio_o(rd_prio),
    .rd_base_o(rd_base), .rd_timer_o(rd_timer)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic get_lock(input int src);
    lock_req[src] = 1'b1;
    @(negedge clk);
    while (!lock_grant[src]) @(negedge clk);
    lock_req[src] = 1'b0;
  endtask

  task automatic issue(input int src, input logic [3:0] op, input int tgt, input int data);
    cmd_valid = 1'b1; cmd_src = IW'(src); cmd_op = op;
    cmd_tgt = IW'(tgt); cmd_data = TW'(data);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_cmd(input int src, input logic [3:0] op, input int tgt, input int data);
    get_lock(src);
    issue(src, op, tgt, data);
    issue(src, C_UNL, 0, 0);
  endtask

  task automatic read_task(input int id);
    rd_id = IW'(id);
    wait_cyc(2);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    wait_cyc(3);
    check("R1 stall in reset", stall, 4'hF);
    check("R1 grant in reset", lock_grant, 0);
    read_task(2);
    check("R1 state in reset", rd_state, S_RDY);
    check("R1 timer in reset", rd_timer, 0);
    check("R1 prio in reset", rd_prio, 0);
    rst = 1'b0;
  endtask

  task automatic t_promote();
    wait_cyc(3);
    check("R2 all released", stall, 4'h0);
    read_task(1);
    check("R2 ready promoted", rd_state, S_RUN);
  endtask

  task automatic t_suspend_resume();
    do_cmd(0, C_SUSP, 2, 0);
    read_task(2);
    check("R3 suspended", rd_state, S_SUS);
    check("R2 suspended stalls", stall[2], 1);
    do_cmd(0, C_RES, 2, 0);
    read_task(2);
    check("R4 resumed runs", rd_state, S_RUN);
    check("R2 resumed released", stall[2], 0);
  endtask

  task automatic t_block_paths();
    do_cmd(1, C_DLY, 0, 0);
    read_task(0);
    check("R5 blocked", rd_state, S_BLK);
    do_cmd(1, C_RES, 0, 0);
    for (int k = 0; k < 3; k++) pulse_tick();
    read_task(0);
    check("R4 resume ignored", rd_state, S_BLK);
    check("R5 zero timer stays", rd_timer, 0);
    check("R2 blocked stalls", stall[0], 1);
    do_cmd(1, C_WAKE, 0, 0);
    read_task(0);
    check("R7 wake runs", rd_state, S_RUN);
    do_cmd(1, C_WAKE, 0, 0);
    read_task(0);
    check("R7 wake ignored on running", rd_state, S_RUN);
    do_cmd(1, C_DLY, 0, 0);
    do_cmd(1, C_SUSP, 0, 0);
    read_task(0);
    check("R3 suspend from blocked", rd_state, S_SUS);
    do_cmd(1, C_RES, 0, 0);
    read_task(0);
    check("R4 resume from suspended", rd_state, S_RUN);
  endtask

  task automatic t_timer();
    do_cmd(2, C_DLY, 3, 5);
    read_task(3);
    check("R5 timer loaded", rd_timer, 5);
    for (int k = 0; k < 4; k++) pulse_tick();
    read_task(3);
    check("R6 timer counted", rd_timer, 1);
    check("R6 still blocked", rd_state, S_BLK);
    pulse_tick();
    read_task(3);
    check("R6 expired runs", rd_state, S_RUN);
    check("R6 timer zero", rd_timer, 0);
    wait_cyc(1);
    check("R6 released", stall[3], 0);
  endtask

  task automatic t_prio();
    do_cmd(3, C_PRIO, 2, 5);
    do_cmd(3, C_BASE, 2, 3);
    read_task(2);
    check("R8 priority", rd_prio, 5);
    check("R8 base priority", rd_base, 3);
  endtask

  task automatic t_lock();
    lock_req = 4'b1010;
    @(negedge clk);
    check("R9 lowest granted", lock_grant, 4'b0010);
    lock_req[1] = 1'b0;
    issue(3, C_SUSP, 0, 0);
    wait_cyc(1);
    check("R9 grant held", lock_grant, 4'b0010);
    issue(1, C_UNL, 0, 0);
    @(negedge clk);
    check("R9 next requester", lock_grant, 4'b1000);
    lock_req = '0;
    issue(3, C_UNL, 0, 0);
    read_task(0);
    check("R10 foreign command ignored", rd_state, S_RUN);
    check("R9 lock free", lock_grant, 0);
  endtask

  task automatic t_dispatch();
    do_cmd(1, C_DOFF, 0, 0);
    wait_cyc(1);
    check("R11 others stalled", stall, 4'b1101);
    do_cmd(0, C_DON, 0, 0);
    wait_cyc(1);
    check("R12 released", stall, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_promote();
    t_suspend_resume();
    t_block_paths();
    t_timer();
    t_prio();
    t_lock();
    t_dispatch();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule